// File: doc/BRIEF.md
# Frequency Counter Gate and Strobe Sequencer

This block turns a free-running 1 MHz system clock into a one-second measurement frame for an external event counter. At the start of every frame it raises a short gate pulse. In the same cycle it asserts a capture strobe, so the external counter's total for the second just ended can be copied into a display register. A fixed number of cycles later it asserts a clear strobe, which zeroes the counter for the next second. The clear strobe always comes after the capture strobe has ended, so no count is cleared before it is captured.

The capture strobe and the clear strobe each have their own polarity-select input, which can be changed while the block runs. The counter and display logic can therefore be either active-high or active-low parts. All outputs come from flip-flops. A polarity change appears on the output after the next clock edge.

All time values are cycle counts set by parameters. The defaults are:
- a frame of 1,000,000 cycles;
- a gate pulse of 200 cycles;
- capture and clear strobes of 50 cycles each;
- a clear delay of 100 cycles, measured from the start of the frame.

Top module: `freq_gate_seq`

## Requirements
- R1: `gate_o` rises once every `PERIOD_CYC` clock cycles.
- R2: `gate_o` is active-high and stays high for exactly `BASE_CYC` cycles of each frame.
- R3: The capture strobe `latch_o` becomes active on the same clock edge that `gate_o` rises, and it stays active for exactly `LATCH_CYC` cycles.
- R4: `latch_pol` sets the level of `latch_o`. With `latch_pol`=0, `latch_o` is active-low and idles at 1. With `latch_pol`=1, it is active-high and idles at 0.
- R5: The clear strobe `clr_o` becomes active `CLR_DELAY_CYC` cycles after `gate_o` rises, and it stays active for `CLR_CYC` cycles. With the default parameters the two strobes are never active in the same cycle.
- R6: `clr_pol` sets the level of `clr_o`. With `clr_pol`=1, `clr_o` is active-high and idles at 0. With `clr_pol`=0, it is active-low and idles at 1.
- R7: While `rst_n` is low, each clock edge drives `gate_o` to 0 and drives both strobes to their inactive levels under the current polarity selects. After `rst_n` goes high, `gate_o` rises on the third rising clock edge and a new frame starts there.
- R8: A change on `latch_pol` or `clr_pol` appears on the matching output after the next rising clock edge, and not before that edge. This holds both when the strobe is idle and when it is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (1 MHz for the default parameters) |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside the block |
| latch_pol | input | 1 | Capture strobe polarity: 1 = active-high, 0 = active-low |
| clr_pol | input | 1 | Clear strobe polarity: 1 = active-high, 0 = active-low |
| gate_o | output | 1 | One-per-frame gate pulse, active-high |
| latch_o | output | 1 | Capture strobe for the external display register |
| clr_o | output | 1 | Clear strobe for the external event counter |

## Verification
The hardest cases to reach from the ports are a polarity flip in the middle of an active strobe, and the exact cycle on which a frame wraps. With the default parameters a frame lasts a million cycles. The bench therefore shrinks the frame to 400 cycles and keeps the strobe windows short and well separated. It then locks onto a rising edge of the gate and compares every output in every cycle of the frame, including the rise that starts the following frame. Each polarity select is flipped at a known cycle, once inside the capture window and once in an idle stretch. The output is sampled both just before and just after the next clock edge.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  // Output level for a strobe: an active strobe drives the selected
  // polarity, an idle strobe drives its complement.
  function automatic logic drive_level(input logic active, input logic active_high);
    return ~(active ^ active_high);
  endfunction

endpackage

// File: rtl/fseq_rst_sync.sv
module fseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/fseq_period_ctr.sv
module fseq_period_ctr #(
  parameter int unsigned PERIOD_CYC = 1_000_000,
  parameter int unsigned CW         = $clog2(PERIOD_CYC)
) (
  input  logic          clk,
  input  logic          srst_n,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q <= LAST);

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/fseq_window_strobe.sv
module fseq_window_strobe #(
  parameter int unsigned CW    = 20,
  parameter int unsigned START = 0,
  parameter int unsigned WIDTH = 50
) (
  input  logic          clk,
  input  logic          run,
  input  logic [CW-1:0] cnt_i,
  input  logic          pol_i,
  output logic          strobe_o
);

  localparam int unsigned STOP    = START + WIDTH;
  localparam logic [CW:0] START_V = (CW+1)'(START);
  localparam logic [CW:0] STOP_V  = (CW+1)'(STOP);

  logic [CW:0] cnt_ext;
  logic        in_win;
  logic        strobe_d;
  logic        strobe_q;

  assign cnt_ext = {1'b0, cnt_i};

  generate
    if (START == 0) begin : g_from_zero
      assign in_win = (cnt_ext < STOP_V);
    end else begin : g_offset
      assign in_win = (cnt_ext >= START_V) && (cnt_ext < STOP_V);
    end
  endgenerate

  always_comb begin
    if (run) begin
      strobe_d = fseq_pkg::drive_level(in_win, pol_i);
    end else begin
      strobe_d = fseq_pkg::drive_level(1'b0, pol_i);
    end
  end

  // The idle level depends on a runtime select, so this register is
  // cleared to that level through the next-state logic while run is low.
  always_ff @(posedge clk) begin
    strobe_q <= strobe_d;
  end

  assign strobe_o = strobe_q;

endmodule

// File: rtl/freq_gate_seq.sv
module freq_gate_seq #(
  parameter int unsigned PERIOD_CYC    = 1_000_000,
  parameter int unsigned BASE_CYC      = 200,
  parameter int unsigned LATCH_CYC     = 50,
  parameter int unsigned CLR_DELAY_CYC = 100,
  parameter int unsigned CLR_CYC       = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_pol,
  input  logic clr_pol,
  output logic gate_o,
  output logic latch_o,
  output logic clr_o
);

  localparam int unsigned CW = $clog2(PERIOD_CYC);

  logic          srst_n;
  logic [CW-1:0] cnt;

  fseq_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  fseq_period_ctr #(
    .PERIOD_CYC (PERIOD_CYC),
    .CW         (CW)
  ) u_ctr (
    .clk    (clk),
    .srst_n (srst_n),
    .cnt_o  (cnt)
  );

  fseq_window_strobe #(
    .CW    (CW),
    .START (0),
    .WIDTH (BASE_CYC)
  ) u_gate (
    .clk      (clk),
    .run      (srst_n),
    .cnt_i    (cnt),
    .pol_i    (1'b1),
    .strobe_o (gate_o)
  );

  fseq_window_strobe #(
    .CW    (CW),
    .START (0),
    .WIDTH (LATCH_CYC)
  ) u_latch (
    .clk      (clk),
    .run      (srst_n),
    .cnt_i    (cnt),
    .pol_i    (latch_pol),
    .strobe_o (latch_o)
  );

  fseq_window_strobe #(
    .CW    (CW),
    .START (CLR_DELAY_CYC),
    .WIDTH (CLR_CYC)
  ) u_clr (
    .clk      (clk),
    .run      (srst_n),
    .cnt_i    (cnt),
    .pol_i    (clr_pol),
    .strobe_o (clr_o)
  );

  // R3
  latch_with_gate_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(gate_o) |-> (latch_o == $past(latch_pol)));

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !((latch_o == $past(latch_pol)) && (clr_o == $past(clr_pol))));

  // R5
  clr_idle_at_gate_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(gate_o) |-> (clr_o != $past(clr_pol)));

endmodule

// File: tb/freq_gate_seq_test.sv
module freq_gate_seq_test;

  localparam int P   = 400;
  localparam int B   = 20;
  localparam int L   = 5;
  localparam int DLY = 10;
  localparam int CL  = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic latch_pol;
  logic clr_pol;
  logic gate_o;
  logic latch_o;
  logic clr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  freq_gate_seq #(
    .PERIOD_CYC    (P),
    .BASE_CYC      (B),
    .LATCH_CYC     (L),
    .CLR_DELAY_CYC (DLY),
    .CLR_CYC       (CL)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_pol (latch_pol),
    .clr_pol   (clr_pol),
    .gate_o    (gate_o),
    .latch_o   (latch_o),
    .clr_o     (clr_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic sync_to_gate_rise();
    logic prev;
    do begin
      prev = gate_o;
      @(negedge clk);
    end while (!(gate_o === 1'b1 && prev === 1'b0));
  endtask

  // R7 R8: outputs under reset follow the current polarity selects
  task automatic t_reset();
    rst_n = 1'b0; latch_pol = 1'b0; clr_pol = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 gate in reset", gate_o, 1'b0);
    chk("R7 latch idle in reset", latch_o, 1'b1);
    chk("R7 clr idle in reset", clr_o, 1'b0);
    latch_pol = 1'b1; clr_pol = 1'b0;
    @(negedge clk);
    chk("R8 latch idle after flip in reset", latch_o, 1'b0);
    chk("R8 clr idle after flip in reset", clr_o, 1'b1);
    latch_pol = 1'b0; clr_pol = 1'b1;
    @(negedge clk);
  endtask

  // R7: first frame starts on the third rising edge after release
  task automatic t_release();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 gate low after edge 1", gate_o, 1'b0);
    @(negedge clk);
    chk("R7 gate low after edge 2", gate_o, 1'b0);
    @(negedge clk);
    chk("R7 gate high after edge 3", gate_o, 1'b1);
    chk("R7 latch active at first frame", latch_o, 1'b0);
  endtask

  // R1..R6: full frame comparison for one polarity pair
  task automatic t_frame(input logic lp, input logic cp);
    latch_pol = lp; clr_pol = cp;
    sync_to_gate_rise();
    for (int i = 0; i <= P; i++) begin
      int  ph;
      bit  la;
      bit  ca;
      ph = i % P;
      la = (ph < L);
      ca = (ph >= DLY) && (ph < DLY + CL);
      chk(i == P ? "R1 next gate rise" : "R2 gate level", gate_o, (ph < B));
      chk(lp ? "R3 R4 latch active-high" : "R3 R4 latch active-low", latch_o, la ? lp : ~lp);
      chk(cp ? "R5 R6 clr active-high" : "R5 R6 clr active-low", clr_o, ca ? cp : ~cp);
      if (i < P) @(negedge clk);
    end
  endtask

  // R8: polarity flips inside an active window and in an idle stretch
  task automatic t_pol_switch();
    latch_pol = 1'b0; clr_pol = 1'b1;
    sync_to_gate_rise();
    @(negedge clk);
    @(negedge clk);
    latch_pol = 1'b1;
    chk("R8 latch unchanged before edge", latch_o, 1'b0);
    @(negedge clk);
    chk("R8 latch active-high after edge", latch_o, 1'b1);
    repeat (DLY + CL + 5 - 3) @(negedge clk);
    clr_pol = 1'b0;
    chk("R8 clr unchanged before edge", clr_o, 1'b0);
    @(negedge clk);
    chk("R8 clr idle-high after edge", clr_o, 1'b1);
    latch_pol = 1'b0;
    @(negedge clk);
    chk("R8 latch idle-high after edge", latch_o, 1'b1);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; latch_pol = 1'b0; clr_pol = 1'b1;
    t_reset();
    t_release();
    t_frame(1'b0, 1'b1);
    t_frame(1'b1, 1'b1);
    t_frame(1'b0, 1'b0);
    t_frame(1'b1, 1'b0);
    t_pol_switch();
    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: got timeout expected completion");
      finish_up();
    end
  end

endmodule